// File: doc/BRIEF.md
# Instruction Decoder and Control-Word Generator

This block turns one 16-bit instruction of a small eight-register, three-address processor into the control word its datapath needs. The word holds the destination and two source register numbers, the select that puts a constant in place of the second operand, the ALU function code, the memory write enable, the select that writes memory data back instead of the ALU result, and the register write enable. It also presents the sign-extended constant, the sign-extended PC-relative offset, a branch condition code, and flags that mark branches and jumps.

The three most significant opcode bits pick one of eight categories, and the category alone fixes the mux and enable settings. The four opcode bits below them go unchanged into the low bits of the ALU function code. The fifth function bit is set by the two shift categories. Opcode bits that a category leaves unused must be zero, and any other value decodes to a no-op.

The decoded word is registered. When `dec_en` is high at a rising clock edge, the decode of `instr` is captured and appears on the outputs one cycle later. When `dec_en` is low, the outputs hold their value. The program counter, register file, ALU and memories sit outside the block.

Top module: `instr_decoder`

## Requirements
- R1: While `rst_n` is low, and right after it is asserted at any time, every output reads zero, which is the no-op word.
- R2: A rising edge with `dec_en` high captures the decode of `instr`, and the result shows on the outputs after that edge. A rising edge with `dec_en` low leaves every output unchanged.
- R3: `dst_addr` is instr[8:6], `srca_addr` is instr[5:3] and `srcb_addr` is instr[2:0], for every category.
- R4: `imm_value` is instr[2:0] read as a two's-complement number and sign-extended to DATA_W bits (3'b100 gives -4).
- R5: `pc_offset` is the 6-bit value {instr[8:6], instr[2:0]} read as two's complement and sign-extended to DATA_W bits, covering -32 to +31.
- R6: Categories 000 (register ALU) and 100 (register shift) give `bsel_const`=0, `wb_from_mem`=0, `reg_we`=1 and `mem_we`=0.
- R7: Categories 001 (immediate ALU) and 101 (immediate shift) give `bsel_const`=1, `wb_from_mem`=0, `reg_we`=1 and `mem_we`=0.
- R8: Category 010 (load) with instr[12:9]=0 gives `wb_from_mem`=1, `reg_we`=1, `mem_we`=0 and `bsel_const`=0.
- R9: Category 011 (store) with instr[12:9]=0 gives `mem_we`=1, `reg_we`=0, `bsel_const`=0 and `wb_from_mem`=0.
- R10: For categories 000, 001, 100 and 101, `alu_func` is {shift, instr[12:9]}, where shift is 1 for 100 and 101 and 0 for 000 and 001. For every other category `alu_func` is 0.
- R11: Category 110 with instr[12]=0 sets `is_branch`=1, sets `branch_cond` to instr[11:9] and clears both write enables. In every other case `branch_cond` is 0.
- R12: Category 111 (jump) with instr[12:9]=0 sets `is_jump`=1 and clears both write enables.
- R13: A reserved encoding decodes to a no-op. The reserved encodings are load, store or jump with instr[12:9] not 0, and branch with instr[12]=1. A no-op has both write enables, both flags, `bsel_const`, `wb_from_mem`, `alu_func` and `branch_cond` at 0, while R3 to R5 still apply.
- R14: At most one of `reg_we`, `mem_we`, `is_branch` and `is_jump` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dec_en | input | 1 | Capture enable for the decoded word |
| instr | input | 16 | Instruction word |
| dst_addr | output | 3 | Destination register number |
| srca_addr | output | 3 | Source A register number |
| srcb_addr | output | 3 | Source B register number |
| bsel_const | output | 1 | 1: constant replaces operand B |
| alu_func | output | 5 | ALU function code |
| mem_we | output | 1 | Data memory write enable |
| wb_from_mem | output | 1 | 1: write memory data back, 0: write ALU result back |
| reg_we | output | 1 | Register file write enable |
| imm_value | output | DATA_W | Sign-extended 3-bit constant |
| pc_offset | output | DATA_W | Sign-extended 6-bit PC-relative offset |
| branch_cond | output | 3 | Branch condition code |
| is_branch | output | 1 | Conditional branch flag |
| is_jump | output | 1 | Jump flag |

## Verification
The assertions check on every cycle that the outputs hold while the enable is low and that the enables and flags stay mutually exclusive. They also check, one cycle after each capture, the register fields, the sign extension of the constant and the offset, the store and immediate settings, the shift bit of the function code, and the no-op result of a reserved load. Only the bench scenarios show the full word for every category, with both used and reserved values of the low opcode bits. The same applies to the boundary offsets -32 and +31, the negative constant, and an asynchronous reset in the middle of a run.

// File: rtl/dec_pkg.sv
package dec_pkg;

  localparam int INSTR_W = 16;
  localparam int RADDR_W = 3;
  localparam int CAT_W   = 3;
  localparam int SUB_W   = 4;
  localparam int FUNC_W  = SUB_W + 1;
  localparam int IMM_W   = 3;
  localparam int OFS_W   = 2 * RADDR_W;
  localparam int COND_W  = 3;

  // Field positions shared by every format
  localparam int CAT_LSB = 13;
  localparam int SUB_LSB = 9;
  localparam int DST_LSB = 6;
  localparam int SRA_LSB = 3;
  localparam int SRB_LSB = 0;

  typedef enum logic [CAT_W-1:0] {
    CAT_REG_ALU   = 3'b000,
    CAT_IMM_ALU   = 3'b001,
    CAT_LOAD      = 3'b010,
    CAT_STORE     = 3'b011,
    CAT_REG_SHIFT = 3'b100,
    CAT_IMM_SHIFT = 3'b101,
    CAT_BRANCH    = 3'b110,
    CAT_JUMP      = 3'b111
  } cat_e;

  typedef struct packed {
    logic bsel_const;
    logic wb_from_mem;
    logic reg_we;
    logic mem_we;
    logic is_branch;
    logic is_jump;
    logic shift_fn;
    logic fwd_fn;
  } sel_t;

  localparam sel_t SEL_NOP = '0;

endpackage

// File: rtl/dec_sext.sv
module dec_sext #(
  parameter int IN_W  = 3,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_in,
  output logic [OUT_W-1:0] val_out
);

  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign val_out = {{PAD_W{val_in[IN_W-1]}}, val_in};
    end else begin : g_same
      assign val_out = val_in[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/dec_category.sv
module dec_category
  import dec_pkg::*;
(
  input  logic [CAT_W-1:0] cat_bits,
  input  logic [SUB_W-1:0] sub_bits,
  output sel_t             sel
);

  cat_e cat;
  logic sub_zero;

  assign cat      = cat_e'(cat_bits);
  assign sub_zero = (sub_bits == '0);

  always_comb begin
    sel = SEL_NOP;
    unique case (cat)
      CAT_REG_ALU: begin
        sel.reg_we = 1'b1;
        sel.fwd_fn = 1'b1;
      end
      CAT_IMM_ALU: begin
        sel.bsel_const = 1'b1;
        sel.reg_we     = 1'b1;
        sel.fwd_fn     = 1'b1;
      end
      CAT_LOAD: begin
        if (sub_zero) begin
          sel.wb_from_mem = 1'b1;
          sel.reg_we      = 1'b1;
        end
      end
      CAT_STORE: begin
        if (sub_zero) begin
          sel.mem_we = 1'b1;
        end
      end
      CAT_REG_SHIFT: begin
        sel.reg_we   = 1'b1;
        sel.shift_fn = 1'b1;
        sel.fwd_fn   = 1'b1;
      end
      CAT_IMM_SHIFT: begin
        sel.bsel_const = 1'b1;
        sel.reg_we     = 1'b1;
        sel.shift_fn   = 1'b1;
        sel.fwd_fn     = 1'b1;
      end
      CAT_BRANCH: begin
        if (!sub_bits[SUB_W-1]) begin
          sel.is_branch = 1'b1;
        end
      end
      CAT_JUMP: begin
        if (sub_zero) begin
          sel.is_jump = 1'b1;
        end
      end
      default: sel = SEL_NOP;
    endcase
  end

endmodule

// File: rtl/dec_word_reg.sv
module dec_word_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) begin
      q_next = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_next;
    end
  end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dec_en,
  input  logic [INSTR_W-1:0]   instr,
  output logic [RADDR_W-1:0]   dst_addr,
  output logic [RADDR_W-1:0]   srca_addr,
  output logic [RADDR_W-1:0]   srcb_addr,
  output logic                 bsel_const,
  output logic [FUNC_W-1:0]    alu_func,
  output logic                 mem_we,
  output logic                 wb_from_mem,
  output logic                 reg_we,
  output logic [DATA_W-1:0]    imm_value,
  output logic [DATA_W-1:0]    pc_offset,
  output logic [COND_W-1:0]    branch_cond,
  output logic                 is_branch,
  output logic                 is_jump
);

  localparam int WORD_W = 3 * RADDR_W + 1 + FUNC_W + 3 + 2 * DATA_W + COND_W + 2;

  logic [CAT_W-1:0]   cat_bits;
  logic [SUB_W-1:0]   sub_bits;
  logic [IMM_W-1:0]   imm_raw;
  logic [OFS_W-1:0]   ofs_raw;
  logic [DATA_W-1:0]  imm_ext;
  logic [DATA_W-1:0]  ofs_ext;
  sel_t               sel;
  logic [FUNC_W-1:0]  func_d;
  logic [COND_W-1:0]  cond_d;
  logic [WORD_W-1:0]  word_d;
  logic [WORD_W-1:0]  word_q;

  assign cat_bits = instr[CAT_LSB +: CAT_W];
  assign sub_bits = instr[SUB_LSB +: SUB_W];
  assign imm_raw  = instr[SRB_LSB +: IMM_W];
  assign ofs_raw  = {instr[DST_LSB +: RADDR_W], instr[SRB_LSB +: RADDR_W]};

  dec_category u_cat (
    .cat_bits (cat_bits),
    .sub_bits (sub_bits),
    .sel      (sel)
  );

  dec_sext #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_imm_ext (
    .val_in  (imm_raw),
    .val_out (imm_ext)
  );

  dec_sext #(.IN_W(OFS_W), .OUT_W(DATA_W)) u_ofs_ext (
    .val_in  (ofs_raw),
    .val_out (ofs_ext)
  );

  assign func_d = sel.fwd_fn    ? {sel.shift_fn, sub_bits}  : '0;
  assign cond_d = sel.is_branch ? sub_bits[COND_W-1:0]      : '0;

  assign word_d = {instr[DST_LSB +: RADDR_W],
                   instr[SRA_LSB +: RADDR_W],
                   instr[SRB_LSB +: RADDR_W],
                   sel.bsel_const,
                   func_d,
                   sel.mem_we,
                   sel.wb_from_mem,
                   sel.reg_we,
                   imm_ext,
                   ofs_ext,
                   cond_d,
                   sel.is_branch,
                   sel.is_jump};

  dec_word_reg #(.W(WORD_W)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (dec_en),
    .d     (word_d),
    .q     (word_q)
  );

  assign {dst_addr, srca_addr, srcb_addr, bsel_const, alu_func, mem_we,
          wb_from_mem, reg_we, imm_value, pc_offset, branch_cond,
          is_branch, is_jump} = word_q;

endmodule

// File: rtl/dec_checker.sv
module dec_checker
  import dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dec_en,
  input logic [INSTR_W-1:0]   instr,
  input logic [RADDR_W-1:0]   dst_addr,
  input logic [RADDR_W-1:0]   srca_addr,
  input logic [RADDR_W-1:0]   srcb_addr,
  input logic                 bsel_const,
  input logic [FUNC_W-1:0]    alu_func,
  input logic                 mem_we,
  input logic                 wb_from_mem,
  input logic                 reg_we,
  input logic [DATA_W-1:0]    imm_value,
  input logic [DATA_W-1:0]    pc_offset,
  input logic [COND_W-1:0]    branch_cond,
  input logic                 is_branch,
  input logic                 is_jump
);

  logic [2:0] cat;
  assign cat = instr[15:13];

  assert_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> (dst_addr == $past(instr[8:6]) && srca_addr == $past(instr[5:3])
                && srcb_addr == $past(instr[2:0])));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> ($stable(reg_we) && $stable(mem_we) && $stable(alu_func)
                 && $stable(imm_value) && $stable(pc_offset) && $stable(dst_addr)
                 && $stable(is_branch) && $stable(is_jump)));

  assert_imm_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> (imm_value[2:0] == $past(instr[2:0])
                && imm_value[DATA_W-1:3] == {(DATA_W-3){$past(instr[2])}}));

  assert_ofs_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> (pc_offset[5:0] == {$past(instr[8:6]), $past(instr[2:0])}
                && pc_offset[DATA_W-1:6] == {(DATA_W-6){$past(instr[8])}}));

  assert_imm_bsel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && (cat == 3'b001 || cat == 3'b101)) |=> (bsel_const && reg_we));

  assert_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && cat == 3'b011 && instr[12:9] == 4'd0) |=> (mem_we && !reg_we));

  assert_shift_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && cat[2:1] == 2'b10) |=> (alu_func == {1'b1, $past(instr[12:9])}));

  assert_reserved_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && cat == 3'b010 && instr[12:9] != 4'd0) |=> (!reg_we && !mem_we && !wb_from_mem));

  assert_exclusive_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, mem_we, is_branch, is_jump}));

endmodule

bind instr_decoder dec_checker #(.DATA_W(DATA_W)) u_dec_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_en      (dec_en),
  .instr       (instr),
  .dst_addr    (dst_addr),
  .srca_addr   (srca_addr),
  .srcb_addr   (srcb_addr),
  .bsel_const  (bsel_const),
  .alu_func    (alu_func),
  .mem_we      (mem_we),
  .wb_from_mem (wb_from_mem),
  .reg_we      (reg_we),
  .imm_value   (imm_value),
  .pc_offset   (pc_offset),
  .branch_cond (branch_cond),
  .is_branch   (is_branch),
  .is_jump     (is_jump)
);

// File: tb/test_instr_decoder.sv
`timescale 1ns/1ps
module test_instr_decoder;

  localparam int DW = 16;
  localparam int VW = 23 + 2 * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dec_en = 1'b0;
  logic [15:0]   instr = '0;
  logic [2:0]    dst_addr, srca_addr, srcb_addr;
  logic          bsel_const;
  logic [4:0]    alu_func;
  logic          mem_we, wb_from_mem, reg_we;
  logic [DW-1:0] imm_value, pc_offset;
  logic [2:0]    branch_cond;
  logic          is_branch, is_jump;

  always #5 clk = ~clk;

  instr_decoder #(.DATA_W(DW)) i_instr_decoder (
    .clk (clk), .rst_n (rst_n), .dec_en (dec_en), .instr (instr),
    .dst_addr (dst_addr), .srca_addr (srca_addr), .srcb_addr (srcb_addr),
    .bsel_const (bsel_const), .alu_func (alu_func), .mem_we (mem_we),
    .wb_from_mem (wb_from_mem), .reg_we (reg_we), .imm_value (imm_value),
    .pc_offset (pc_offset), .branch_cond (branch_cond),
    .is_branch (is_branch), .is_jump (is_jump)
  );

  typedef struct {
    logic [VW-1:0] v;
    string         tag;
  } item_t;

  item_t         sb[$];
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;
  logic [VW-1:0] last_exp = '0;

  wire [VW-1:0] got = {dst_addr, srca_addr, srcb_addr, bsel_const, alu_func,
                       mem_we, wb_from_mem, reg_we, imm_value, pc_offset,
                       branch_cond, is_branch, is_jump};

  // Reference built from the requirement text
  function automatic logic [VW-1:0] model(input logic [15:0] i);
    logic [2:0] c;
    logic [3:0] lo;
    logic bs, mw, wm, rw, br, jp;
    logic [4:0] fn;
    logic [2:0] cd;
    logic [DW-1:0] imm, ofs;
    c = i[15:13]; lo = i[12:9];
    bs = 0; mw = 0; wm = 0; rw = 0; br = 0; jp = 0; fn = '0; cd = '0;
    imm = {{(DW-3){i[2]}}, i[2:0]};                // R4
    ofs = {{(DW-6){i[8]}}, i[8:6], i[2:0]};        // R5
    case (c)
      3'd0: begin rw = 1; fn = {1'b0, lo}; end                  // R6 R10
      3'd1: begin bs = 1; rw = 1; fn = {1'b0, lo}; end          // R7 R10
      3'd2: if (lo == 0) begin wm = 1; rw = 1; end              // R8 R13
      3'd3: if (lo == 0) mw = 1;                                // R9 R13
      3'd4: begin rw = 1; fn = {1'b1, lo}; end                  // R6 R10
      3'd5: begin bs = 1; rw = 1; fn = {1'b1, lo}; end          // R7 R10
      3'd6: if (!lo[3]) begin br = 1; cd = lo[2:0]; end         // R11 R13
      default: if (lo == 0) jp = 1;                             // R12 R13
    endcase
    return {i[8:6], i[5:3], i[2:0], bs, fn, mw, wm, rw, imm, ofs, cd, br, jp};
  endfunction

  function automatic string tag_of(input logic [15:0] i);
    string t;
    case (i[15:13])
      3'd0, 3'd4: t = "R6";
      3'd1, 3'd5: t = "R7";
      3'd2:       t = (i[12:9] == 0) ? "R8" : "R13";
      3'd3:       t = (i[12:9] == 0) ? "R9" : "R13";
      3'd6:       t = (!i[12]) ? "R11" : "R13";
      default:    t = (i[12:9] == 0) ? "R12" : "R13";
    endcase
    return {t, " R3 R4 R5 R10"};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one instruction per cycle, expected word queued
  task automatic send(input logic [15:0] i);
    item_t it;
    @(negedge clk);
    instr  = i;
    dec_en = 1'b1;
    it.v   = model(i);
    it.tag = tag_of(i);
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    dec_en = 1'b0;
  endtask

  // Monitor: compares one cycle after each capture
  initial begin
    bit cap;
    item_t it;
    forever begin
      @(posedge clk);
      cap = dec_en && rst_n;
      @(negedge clk);
      if (cap) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected capture", got, '0);
        end else begin
          it = sb.pop_front();
          check(got === it.v, it.tag, got, it.v);
          check($countones({reg_we, mem_we, is_branch, is_jump}) <= 1, "R14", got, it.v);
          last_exp = it.v;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] los [5];
    los[0] = 4'd0; los[1] = 4'd1; los[2] = 4'd8; los[3] = 4'd12; los[4] = 4'd15;

    // R1: reset state
    repeat (2) @(negedge clk);
    check(got === '0, "R1 in reset", got, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(got === '0, "R1 after release", got, '0);

    // Named corner cases
    send({3'b000, 4'b1100, 3'd1, 3'd2, 3'd3});   // register XOR
    send({3'b101, 4'b1000, 3'd4, 3'd5, 3'd7});   // immediate shift left, constant -1
    send({3'b001, 4'b0010, 3'd0, 3'd6, 3'b100}); // constant -4
    send({3'b110, 4'b0011, 3'b100, 3'd3, 3'b000}); // branch if zero, offset -32
    send({3'b111, 4'b0000, 3'b011, 3'd0, 3'b111}); // jump +31
    send({3'b010, 4'b0000, 3'd7, 3'd1, 3'd0});   // load
    send({3'b011, 4'b0000, 3'd0, 3'd2, 3'd5});   // store
    send({3'b110, 4'b1011, 3'd1, 3'd1, 3'd1});   // reserved branch
    send({3'b011, 4'b0100, 3'd1, 3'd2, 3'd3});   // reserved store

    // Sweep of every category with used and reserved low opcode bits
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 5; k++) begin
        logic [8:0] p;
        logic [2:0] cc;
        p  = 9'((c * 73 + k * 151 + 17) % 512);
        cc = 3'(c);
        send({cc, los[k], p});
      end
    end
    idle();
    wait (sb.size() == 0);
    @(negedge clk);

    // R2: outputs hold while enable is low
    instr = 16'hFFFF;
    repeat (3) @(negedge clk);
    check(got === last_exp, "R2 hold", got, last_exp);
    instr = 16'h0000;
    @(negedge clk);
    check(got === last_exp, "R2 hold after input change", got, last_exp);

    // R1: asynchronous reset mid-run
    send({3'b000, 4'b0001, 3'd7, 3'd7, 3'd7});
    idle();
    wait (sb.size() == 0);
    #2;
    rst_n = 1'b0;
    #1;
    check(got === '0, "R1 async reset", got, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule